// File: doc/BRIEF.md
# WAN Frame Trap Classifier

This block watches a byte-wide frame stream coming from the WAN side and decides, once per frame, whether the frame should be diverted to an extract queue (trapped) or passed on normally. The decision comes from three trap sources. Each source has its own enable, and the result is the OR of the enabled sources that fire.

- **VLAN source.** A VLAN-table lookup result arrives alongside the frame. It can request extraction, but only when the frame's source port is allowed to feed the extract queue.
- **Ethernet Type source.** A programmable 16-bit value is compared against a byte pair at a programmable offset. Only offsets inside the first 32 bytes of the frame are used.
- **Header source.** A programmable 16-bit value is compared against a byte pair at an offset inside the first 8 bytes.

The decision is registered. It is presented as a single-cycle strobe carrying the hit flag and a per-source bit vector. Surrounding logic uses that strobe to steer the frame. The block does not store frames.

Top module: `wan_trap_classifier`

## Requirements
- R1: While reset is high and in the first cycle after it, `trap_valid`, `trap_hit` and `trap_src` are all zero.
- R2: Each frame produces exactly one `trap_valid` pulse. The pulse comes in the cycle after the accepted beat that is either the frame's last byte (`in_eof`) or its byte index 31, whichever comes first (the `in_sof` byte is index 0). Beats that follow the deciding beat, up to the next `in_sof`, produce no further pulse.
- R3: `trap_src[1]` (Ethernet Type) is set when `cfg_et_en` is high and bytes `cfg_et_off` and `cfg_et_off+1` equal `cfg_et_val`, with the earlier byte as the upper 8 bits.
- R4: The Ethernet Type source misses in two cases. The first is when `cfg_et_off` is greater than 30. The second is when the frame ends before byte `cfg_et_off+1`.
- R5: `trap_src[2]` (header) is set when `cfg_hdr_en` is high, `cfg_hdr_off` is 0 to 6, and bytes `cfg_hdr_off` and `cfg_hdr_off+1` equal `cfg_hdr_val`, with the earlier byte as the upper 8 bits. It misses when the frame ends before byte `cfg_hdr_off+1`.
- R6: A header offset of 7, where the pair would reach past byte 7, is always a header miss.
- R7: `trap_src[0]` (VLAN) is set when `cfg_vlan_en` is high and `vlan_res` equals the extract code 4'hE while `vlan_res_valid` is high. The strobe must fall in any cycle from the `in_sof` beat through the deciding beat, inclusive. The frame's port must also be allowed, as in R8.
- R8: The frame's port is `in_port`, sampled on the `in_sof` beat. A VLAN extract result is ignored when bit `port` of `cfg_fwd_mask` is clear. Codes other than 4'hE never set the VLAN bit.
- R9: A disabled source never sets its bit. `trap_hit` is the OR of the bits of `trap_src`, and both are zero whenever `trap_valid` is low.
- R10: `cfg_fwd_mask` has at most one bit set, since only one port may feed the extract queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Byte beat valid |
| in_sof | input | 1 | Beat is the first byte of a frame |
| in_eof | input | 1 | Beat is the last byte of a frame |
| in_data | input | 8 | Frame byte |
| in_port | input | PORT_W | Source port, sampled with `in_sof` |
| vlan_res_valid | input | 1 | VLAN lookup result strobe |
| vlan_res | input | 4 | VLAN lookup result code |
| cfg_fwd_mask | input | NPORTS | Ports allowed to feed the extract queue |
| cfg_vlan_en | input | 1 | VLAN source enable |
| cfg_et_en | input | 1 | Ethernet Type source enable |
| cfg_et_val | input | 16 | Ethernet Type compare value |
| cfg_et_off | input | ET_OFF_W | Ethernet Type byte offset |
| cfg_hdr_en | input | 1 | Header source enable |
| cfg_hdr_val | input | 16 | Header compare value |
| cfg_hdr_off | input | HDR_OFF_W | Header byte offset |
| trap_valid | output | 1 | One-cycle decision strobe per frame |
| trap_hit | output | 1 | Frame is trapped |
| trap_src | output | 3 | Firing sources: [0] VLAN, [1] Ethernet Type, [2] header |

## Verification
Random frames of 1 to 48 bytes are sent with random offsets, enables, ports and lookup codes. The compare values are often planted at the configured offset, so hits and misses occur in similar numbers. This separates an offset or byte-order error from a plain miss. Directed frames cover several edges:
- frames cut off exactly at the second byte of a pair;
- Ethernet Type offsets 30 and 31;
- header offsets 6 and 7;
- back-to-back one-byte frames;
- long frames with a VLAN strobe just before, on, and after the deciding beat.

Together these separate an off-by-one in the decision timing from an error in the window bounds. A forwarding mask that excludes the frame's port shows whether the port gate is applied.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int SRC_VLAN = 0;
  localparam int SRC_ET   = 1;
  localparam int SRC_HDR  = 2;
  localparam int NSRC     = 3;
  typedef logic [NSRC-1:0] trap_src_t;
  localparam logic [3:0] VLAN_EXTRACT_CODE = 4'hE;
endpackage

// File: rtl/trap_beat_tracker.sv
module trap_beat_tracker #(
  parameter int DEC_WIN = 32,
  parameter int IDX_W   = $clog2(DEC_WIN) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             in_sof,
  input  logic             in_eof,
  output logic             beat,
  output logic             sof_beat,
  output logic             active,
  output logic [IDX_W-1:0] idx,
  output logic             decide
);
  localparam logic [IDX_W-1:0] CNT_MAX  = '1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEC_WIN - 1);

  logic [IDX_W-1:0] cnt;
  logic             act_q;

  assign sof_beat = in_valid && in_sof;
  assign beat     = in_valid && (in_sof || act_q);
  assign idx      = in_sof ? '0 : cnt;
  assign decide   = beat && (in_eof || idx == LAST_IDX);
  assign active   = act_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      act_q <= 1'b0;
    end else if (beat) begin
      cnt   <= (idx == CNT_MAX) ? CNT_MAX : idx + 1'b1;
      act_q <= !decide;
    end
  end
endmodule

// File: rtl/trap_pair_match.sv
module trap_pair_match #(
  parameter int WIN   = 8,
  parameter int OFF_W = 3,
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             beat,
  input  logic             sof_beat,
  input  logic [IDX_W-1:0] idx,
  input  logic [7:0]       prev_byte,
  input  logic [7:0]       cur_byte,
  input  logic [OFF_W-1:0] off,
  input  logic [15:0]      val,
  output logic             hit
);
  localparam int CW = (IDX_W > OFF_W ? IDX_W : OFF_W) + 1;
  localparam logic [OFF_W-1:0] OFF_LIMIT = OFF_W'(WIN - 2);

  logic [CW-1:0] target;
  logic          off_ok;
  logic          cur_hit;
  logic          acc;

  assign target  = CW'(off) + CW'(1);
  assign off_ok  = off <= OFF_LIMIT;
  assign cur_hit = beat && off_ok && (CW'(idx) == target) &&
                   ({prev_byte, cur_byte} == val);
  assign hit     = cur_hit || (acc && !sof_beat);

  always_ff @(posedge clk) begin
    if (rst)           acc <= 1'b0;
    else if (sof_beat) acc <= cur_hit;
    else if (beat)     acc <= acc || cur_hit;
  end
endmodule

// File: rtl/trap_vlan_gate.sv
module trap_vlan_gate #(
  parameter int NPORTS = 4,
  parameter int PORT_W = $clog2(NPORTS),
  parameter logic [3:0] EXTRACT = 4'hE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sof_beat,
  input  logic              active,
  input  logic [PORT_W-1:0] in_port,
  input  logic              vlan_res_valid,
  input  logic [3:0]        vlan_res,
  input  logic [NPORTS-1:0] cfg_fwd_mask,
  output logic              hit
);
  logic [PORT_W-1:0] port_q;
  logic [PORT_W-1:0] port_cur;
  logic              cur_ext;
  logic              acc;
  logic              port_ok;

  assign port_cur = sof_beat ? in_port : port_q;
  assign port_ok  = cfg_fwd_mask[port_cur];
  assign cur_ext  = vlan_res_valid && (vlan_res == EXTRACT) && (active || sof_beat);
  assign hit      = port_ok && (cur_ext || (acc && !sof_beat));

  always_ff @(posedge clk) begin
    if (rst) begin
      port_q <= '0;
      acc    <= 1'b0;
    end else if (sof_beat) begin
      port_q <= in_port;
      acc    <= cur_ext;
    end else if (active) begin
      acc    <= acc || cur_ext;
    end
  end
endmodule

// File: rtl/wan_trap_classifier.sv
module wan_trap_classifier
  import trap_pkg::*;
#(
  parameter int NPORTS    = 4,
  parameter int PORT_W    = $clog2(NPORTS),
  parameter int ET_WIN    = 32,
  parameter int HDR_WIN   = 8,
  parameter int ET_OFF_W  = 6,
  parameter int HDR_OFF_W = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic                 in_sof,
  input  logic                 in_eof,
  input  logic [7:0]           in_data,
  input  logic [PORT_W-1:0]    in_port,
  input  logic                 vlan_res_valid,
  input  logic [3:0]           vlan_res,
  input  logic [NPORTS-1:0]    cfg_fwd_mask,
  input  logic                 cfg_vlan_en,
  input  logic                 cfg_et_en,
  input  logic [15:0]          cfg_et_val,
  input  logic [ET_OFF_W-1:0]  cfg_et_off,
  input  logic                 cfg_hdr_en,
  input  logic [15:0]          cfg_hdr_val,
  input  logic [HDR_OFF_W-1:0] cfg_hdr_off,
  output logic                 trap_valid,
  output logic                 trap_hit,
  output logic [NSRC-1:0]      trap_src
);
  localparam int IDX_W = $clog2(ET_WIN) + 1;

  logic             beat, sof_beat, active, decide;
  logic [IDX_W-1:0] idx;
  logic [7:0]       prev_byte;
  logic             et_hit, hdr_hit, vlan_hit;
  trap_src_t        src_next;

  trap_beat_tracker #(.DEC_WIN(ET_WIN), .IDX_W(IDX_W)) u_track (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof),
    .beat(beat), .sof_beat(sof_beat), .active(active), .idx(idx), .decide(decide)
  );

  always_ff @(posedge clk) begin
    if (rst)       prev_byte <= '0;
    else if (beat) prev_byte <= in_data;
  end

  trap_pair_match #(.WIN(ET_WIN), .OFF_W(ET_OFF_W), .IDX_W(IDX_W)) u_et (
    .clk(clk), .rst(rst), .beat(beat), .sof_beat(sof_beat), .idx(idx),
    .prev_byte(prev_byte), .cur_byte(in_data), .off(cfg_et_off),
    .val(cfg_et_val), .hit(et_hit)
  );

  trap_pair_match #(.WIN(HDR_WIN), .OFF_W(HDR_OFF_W), .IDX_W(IDX_W)) u_hdr (
    .clk(clk), .rst(rst), .beat(beat), .sof_beat(sof_beat), .idx(idx),
    .prev_byte(prev_byte), .cur_byte(in_data), .off(cfg_hdr_off),
    .val(cfg_hdr_val), .hit(hdr_hit)
  );

  trap_vlan_gate #(.NPORTS(NPORTS), .PORT_W(PORT_W), .EXTRACT(VLAN_EXTRACT_CODE)) u_vlan (
    .clk(clk), .rst(rst), .sof_beat(sof_beat), .active(active), .in_port(in_port),
    .vlan_res_valid(vlan_res_valid), .vlan_res(vlan_res),
    .cfg_fwd_mask(cfg_fwd_mask), .hit(vlan_hit)
  );

  always_comb begin
    src_next           = '0;
    src_next[SRC_VLAN] = cfg_vlan_en && vlan_hit;
    src_next[SRC_ET]   = cfg_et_en && et_hit;
    src_next[SRC_HDR]  = cfg_hdr_en && hdr_hit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      trap_valid <= 1'b0;
      trap_hit   <= 1'b0;
      trap_src   <= '0;
    end else begin
      trap_valid <= decide;
      trap_hit   <= decide && (|src_next);
      trap_src   <= decide ? src_next : '0;
    end
  end
endmodule

// File: rtl/wan_trap_checker.sv
module wan_trap_checker #(
  parameter int NPORTS    = 4,
  parameter int PORT_W    = 2,
  parameter int ET_WIN    = 32,
  parameter int HDR_WIN   = 8,
  parameter int ET_OFF_W  = 6,
  parameter int HDR_OFF_W = 3
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 in_valid,
  input logic [NPORTS-1:0]    cfg_fwd_mask,
  input logic                 cfg_vlan_en,
  input logic                 cfg_et_en,
  input logic [ET_OFF_W-1:0]  cfg_et_off,
  input logic                 cfg_hdr_en,
  input logic [HDR_OFF_W-1:0] cfg_hdr_off,
  input logic                 trap_valid,
  input logic                 trap_hit,
  input logic [2:0]           trap_src
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!trap_valid && !trap_hit && trap_src == 3'b000));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !trap_valid |-> (!trap_hit && trap_src == 3'b000));

  // R9
  hit_or_chk: assert property (@(posedge clk) disable iff (rst)
    trap_valid |-> (trap_hit == (trap_src != 3'b000)));

  // R2
  pulse_after_beat_chk: assert property (@(posedge clk) disable iff (rst)
    trap_valid |-> $past(in_valid));

  // R7
  vlan_enable_chk: assert property (@(posedge clk) disable iff (rst)
    trap_src[0] |-> $past(cfg_vlan_en));

  // R4
  et_window_chk: assert property (@(posedge clk) disable iff (rst)
    trap_src[1] |-> ($past(cfg_et_en) && (int'($past(cfg_et_off)) <= ET_WIN - 2)));

  // R6
  hdr_window_chk: assert property (@(posedge clk) disable iff (rst)
    trap_src[2] |-> ($past(cfg_hdr_en) && (int'($past(cfg_hdr_off)) <= HDR_WIN - 2)));

  // R10
  single_port_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cfg_fwd_mask));
endmodule

bind wan_trap_classifier wan_trap_checker #(
  .NPORTS(NPORTS), .PORT_W(PORT_W), .ET_WIN(ET_WIN), .HDR_WIN(HDR_WIN),
  .ET_OFF_W(ET_OFF_W), .HDR_OFF_W(HDR_OFF_W)
) i_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .cfg_fwd_mask(cfg_fwd_mask),
  .cfg_vlan_en(cfg_vlan_en), .cfg_et_en(cfg_et_en), .cfg_et_off(cfg_et_off),
  .cfg_hdr_en(cfg_hdr_en), .cfg_hdr_off(cfg_hdr_off),
  .trap_valid(trap_valid), .trap_hit(trap_hit), .trap_src(trap_src)
);

// File: tb/test_wan_trap_classifier.sv
`timescale 1ns/1ps
module test_wan_trap_classifier;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 0, in_sof = 0, in_eof = 0;
  logic [7:0]  in_data = 0;
  logic [1:0]  in_port = 0;
  logic        vlan_res_valid = 0;
  logic [3:0]  vlan_res = 0;
  logic [3:0]  cfg_fwd_mask = 0;
  logic        cfg_vlan_en = 0, cfg_et_en = 0, cfg_hdr_en = 0;
  logic [15:0] cfg_et_val = 0, cfg_hdr_val = 0;
  logic [5:0]  cfg_et_off = 0;
  logic [2:0]  cfg_hdr_off = 0;
  logic        trap_valid, trap_hit;
  logic [2:0]  trap_src;

  int checks = 0, errors = 0, cycles = 0;
  logic [7:0] fbuf [0:63];

  always #2.5 clk = ~clk;

  wan_trap_classifier i_wan_trap_classifier (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof),
    .in_data(in_data), .in_port(in_port), .vlan_res_valid(vlan_res_valid),
    .vlan_res(vlan_res), .cfg_fwd_mask(cfg_fwd_mask), .cfg_vlan_en(cfg_vlan_en),
    .cfg_et_en(cfg_et_en), .cfg_et_val(cfg_et_val), .cfg_et_off(cfg_et_off),
    .cfg_hdr_en(cfg_hdr_en), .cfg_hdr_val(cfg_hdr_val), .cfg_hdr_off(cfg_hdr_off),
    .trap_valid(trap_valid), .trap_hit(trap_hit), .trap_src(trap_src)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit pair_hit(input int len, input int off, input int lim,
                                  input logic [15:0] val);
    if (off > lim - 2 || off + 1 >= len) return 1'b0;
    return {fbuf[off], fbuf[off+1]} == val;
  endfunction

  // vs: beat index of the VLAN strobe, -1 for none
  task automatic send_frame(input int len, input int vs, input logic [3:0] code, input int gap);
    int d = (len - 1 < 31) ? len - 1 : 31;
    int pulses = 0;
    logic [2:0] got = 3'b000;
    logic       got_hit = 1'b0;
    logic [2:0] exp;
    exp[0] = cfg_vlan_en && vs >= 0 && vs <= d && code == 4'hE && cfg_fwd_mask[in_port];
    exp[1] = cfg_et_en  && pair_hit(len, int'(cfg_et_off), 32, cfg_et_val);
    exp[2] = cfg_hdr_en && pair_hit(len, int'(cfg_hdr_off), 8, cfg_hdr_val);
    for (int i = 0; i < len; i++) begin
      in_valid = 1'b1;
      in_sof = (i == 0);
      in_eof = (i == len - 1);
      in_data = fbuf[i];
      vlan_res_valid = (i == vs);
      vlan_res = code;
      @(negedge clk);
      if (trap_valid) begin
        pulses++;
        got = trap_src;
        got_hit = trap_hit;
        check("R2 pulse beat", i, d + 1 > len ? len : d + 1 - 1 + 0);
      end
    end
    in_valid = 0; in_sof = 0; in_eof = 0; vlan_res_valid = 0;
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      if (trap_valid) pulses++;
    end
    check("R2 pulses", pulses, 1);
    check("R7/R8 vlan", int'(got[0]), int'(exp[0]));
    check("R3/R4 etype", int'(got[1]), int'(exp[1]));
    check("R5/R6 header", int'(got[2]), int'(exp[2]));
    check("R9 hit", int'(got_hit), int'(|exp));
  endtask

  task automatic fill(input int len);
    for (int i = 0; i < 64; i++) fbuf[i] = (i < len) ? 8'($urandom) : 8'h00;
  endtask

  initial begin
    while (cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    errors++;
    $display("FAIL watchdog: actual %0d expected below %0d", cycles, 150000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 valid", int'(trap_valid), 0);
    check("R1 src", int'(trap_src), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after", int'(trap_hit), 0);

    cfg_et_en = 1; cfg_hdr_en = 1; cfg_vlan_en = 1;
    cfg_et_val = 16'h8100; cfg_hdr_val = 16'hA55A;
    cfg_fwd_mask = 4'b0100; in_port = 2;

    // R3 and R4 boundary at offsets 30 and 31, long frame
    fill(48); fbuf[30] = 8'h81; fbuf[31] = 8'h00; cfg_et_off = 30;
    send_frame(48, -1, 4'h0, 2);
    fill(48); fbuf[31] = 8'h81; fbuf[32] = 8'h00; cfg_et_off = 31;
    send_frame(48, -1, 4'h0, 2);
    // R4 frame ends on the first byte of the pair
    fill(12); fbuf[10] = 8'h81; fbuf[11] = 8'h00; cfg_et_off = 11;
    send_frame(12, -1, 4'h0, 1);
    // R5 header at offset 6, R6 offset 7
    fill(20); fbuf[6] = 8'hA5; fbuf[7] = 8'h5A; cfg_hdr_off = 6;
    send_frame(20, -1, 4'h0, 1);
    fill(20); fbuf[7] = 8'hA5; fbuf[8] = 8'h5A; cfg_hdr_off = 7;
    send_frame(20, -1, 4'h0, 1);
    // R5 pair cut by frame end
    fill(7); fbuf[5] = 8'hA5; fbuf[6] = 8'h5A; cfg_hdr_off = 6;
    send_frame(7, -1, 4'h0, 1);
    // R7 strobe on, before, and after deciding beat
    fill(40); send_frame(40, 31, 4'hE, 1);
    fill(40); send_frame(40, 0, 4'hE, 1);
    fill(40); send_frame(40, 32, 4'hE, 1);
    // R8 port not allowed, and non-extract code
    cfg_fwd_mask = 4'b0001;
    fill(10); send_frame(10, 3, 4'hE, 1);
    cfg_fwd_mask = 4'b0100;
    fill(10); send_frame(10, 3, 4'h7, 1);
    // R2 back-to-back one-byte frames
    fill(1); send_frame(1, 0, 4'hE, 0);
    fill(1); send_frame(1, -1, 4'h0, 0);
    fill(1); send_frame(1, 0, 4'hE, 2);

    // random mix
    for (int n = 0; n < 400; n++) begin
      int len = 1 + int'($urandom_range(47));
      int vs;
      logic [3:0] code;
      fill(len);
      cfg_vlan_en = 1'($urandom); cfg_et_en = 1'($urandom); cfg_hdr_en = 1'($urandom);
      cfg_et_val = 16'($urandom); cfg_hdr_val = 16'($urandom);
      cfg_et_off = 6'($urandom_range(40));
      cfg_hdr_off = 3'($urandom);
      cfg_fwd_mask = ($urandom_range(3) == 0) ? 4'b0000 : 4'(1 << $urandom_range(3));
      in_port = 2'($urandom);
      if ($urandom_range(1) == 1) begin
        if (int'(cfg_et_off) < 63) begin
          fbuf[cfg_et_off] = cfg_et_val[15:8];
          fbuf[int'(cfg_et_off) + 1] = cfg_et_val[7:0];
        end
      end
      if ($urandom_range(1) == 1) begin
        fbuf[cfg_hdr_off] = cfg_hdr_val[15:8];
        fbuf[int'(cfg_hdr_off) + 1] = cfg_hdr_val[7:0];
      end
      vs = int'($urandom_range(len)) - 1;
      code = ($urandom_range(1) == 1) ? 4'hE : 4'($urandom);
      send_frame(len, vs, code, int'($urandom_range(2)));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule